// File: doc/BRIEF.md
# 16-bit Address Arithmetic Unit

This unit does the pointer and stack arithmetic of a small 8-bit processor core. Each operation is selected by a code. It can add a register pair into the HL pair, step a pair or the stack pointer up or down by one, or add a signed byte to the stack pointer, with the sum bound for either SP or HL. It also applies the step after an access made through HL, forms the target of a relative branch, and decides whether a branch condition holds. The unit has no state of its own apart from its output registers. The register file, the bus sequencing and the program counter stay with the caller, which supplies the operands and writes the result back.

An operation is presented with `op_valid` high for one cycle. On the next clock edge the unit captures the 16-bit result, the four-bit flag word and the condition outcome, and raises `res_valid` for one cycle. Every 16-bit result wraps modulo 65536 and gives no overflow indication. The flag word is packed with Z at bit 3, N at bit 2, H at bit 1 and C at bit 0, on both input and output.

Top module: `addr_alu`

## Requirements
- R1: Op code 0 (pair add) returns `opnd_a + opnd_b`. N is cleared, H is set on a carry out of bit 11, C is set on a carry out of bit 15, and Z is copied from `flags_in`.
- R2: Op codes 3 (offset to SP) and 4 (offset to HL) both return `opnd_a` plus the sign-extended `offset` byte, and both force Z=0 and N=0. H is the carry out of bit 3 and C is the carry out of bit 7 of the unsigned sum of the low byte of `opnd_a` and the raw offset byte.
- R3: Op codes 1 (increment) and 2 (decrement) return `opnd_a` plus one or minus one, and pass `flags_in` to `flags_out` unchanged.
- R4: Op codes 5 (pointer post-increment) and 6 (pointer post-decrement) return the HL value in `opnd_a` stepped by +1 or -1, and leave the flags unchanged.
- R5: Op code 7 (conditional relative branch) returns `opnd_a` plus the sign-extended offset in the range -128..+127. The flags are unchanged, and `cond_met` shows whether the condition holds.
- R6: `cond_sel` encodes the condition as follows: 0 = Z clear, 1 = Z set, 2 = C clear, 3 = C set. The condition is evaluated against `flags_in`.
- R7: Op code 8 (unconditional relative branch) computes the same target as op code 7 and drives `cond_met` to 1. Op codes 0 to 6 drive `cond_met` to 0.
- R8: A valid operation sampled on one rising edge appears on the outputs after that edge, with `res_valid` high for exactly one cycle.
- R9: When `op_valid` is low, or the op code is 9 to 15, `res_valid` is 0 on the following cycle and `res_out`, `flags_out` and `cond_met` keep their previous values.
- R10: Synchronous reset clears `res_out`, `flags_out`, `cond_met` and `res_valid` to 0.
- R11: Results wrap modulo 65536: 0xFFFF+1 gives 0x0000 and 0x0000-1 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 16 | First operand (HL, SP, pair or current address) |
| opnd_b | input | 16 | Second operand for the pair add |
| offset | input | 8 | Signed byte offset |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| cond_sel | input | 2 | Branch condition select |
| res_out | output | 16 | Registered 16-bit result |
| flags_out | output | 4 | Registered updated flags {Z,N,H,C} |
| cond_met | output | 1 | Registered branch-taken decision |
| res_valid | output | 1 | Result captured on the last edge |

## Verification
Every result has a latency of one clock. Operands driven at a falling edge are captured by the next rising edge, so the result, the flags and the condition outcome are all due at the falling edge that follows. Each scenario task drives its operands at a falling edge, drops `op_valid` at the next falling edge, and compares all four outputs right then against values worked out from the requirements. The idle cycle after that is checked separately, to confirm that `res_valid` has fallen and that the outputs have held.

// File: rtl/addr_alu_pkg.sv
package addr_alu_pkg;
  localparam int FLAG_W = 4;
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  typedef enum logic [3:0] {
    OP_PAIR_ADD = 4'd0,
    OP_INC      = 4'd1,
    OP_DEC      = 4'd2,
    OP_OFS_SP   = 4'd3,
    OP_OFS_HL   = 4'd4,
    OP_PTR_INC  = 4'd5,
    OP_PTR_DEC  = 4'd6,
    OP_JR_COND  = 4'd7,
    OP_JR       = 4'd8
  } aop_e;

  typedef enum logic [1:0] {
    CC_ZCLR = 2'd0,
    CC_ZSET = 2'd1,
    CC_CCLR = 2'd2,
    CC_CSET = 2'd3
  } acond_e;
endpackage

// File: rtl/addr_pair_add.sv
module addr_pair_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         half_cy,
  output logic         full_cy
);
  localparam int LO_W = W - 4;
  logic [W:0]    wide;
  logic [LO_W:0] low;

  always_comb begin
    wide    = {1'b0, a} + {1'b0, b};
    low     = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]};
    sum     = wide[W-1:0];
    full_cy = wide[W];
    half_cy = low[LO_W];
  end
endmodule

// File: rtl/addr_offset_add.sv
module addr_offset_add #(
  parameter int W   = 16,
  parameter int O_W = 8
) (
  input  logic [W-1:0]   base,
  input  logic [O_W-1:0] ofs,
  output logic [W-1:0]   sum,
  output logic           nib_cy,
  output logic           byte_cy
);
  localparam int NIB = O_W / 2;
  logic [W-1:0] ofs_ext;
  logic [O_W:0] byte_sum;
  logic [NIB:0] nib_sum;

  always_comb begin
    ofs_ext  = {{(W-O_W){ofs[O_W-1]}}, ofs};
    sum      = base + ofs_ext;
    byte_sum = {1'b0, base[O_W-1:0]} + {1'b0, ofs};
    nib_sum  = {1'b0, base[NIB-1:0]} + {1'b0, ofs[NIB-1:0]};
    byte_cy  = byte_sum[O_W];
    nib_cy   = nib_sum[NIB];
  end
endmodule

// File: rtl/addr_step.sv
module addr_step #(
  parameter int W    = 16,
  parameter bit DOWN = 1'b0
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] nxt
);
  generate
    if (DOWN) begin : g_dn
      assign nxt = val - W'(1);
    end else begin : g_up
      assign nxt = val + W'(1);
    end
  endgenerate
endmodule

// File: rtl/addr_cond_eval.sv
module addr_cond_eval
  import addr_alu_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [1:0]        sel,
  output logic              taken
);
  always_comb begin
    unique case (sel)
      CC_ZCLR: taken = ~flags[FZ];
      CC_ZSET: taken =  flags[FZ];
      CC_CCLR: taken = ~flags[FC];
      default: taken =  flags[FC];
    endcase
  end
endmodule

// File: rtl/addr_alu.sv
module addr_alu
  import addr_alu_pkg::*;
#(
  parameter int W   = 16,
  parameter int O_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_sel,
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  input  logic [O_W-1:0]    offset,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [1:0]        cond_sel,
  output logic [W-1:0]      res_out,
  output logic [FLAG_W-1:0] flags_out,
  output logic              cond_met,
  output logic              res_valid
);
  logic [W-1:0] pair_sum, ofs_sum, up_val, dn_val;
  logic         pair_h, pair_c, ofs_h, ofs_c, cc_ok;

  addr_pair_add #(.W(W)) u_pair (
    .a(opnd_a), .b(opnd_b), .sum(pair_sum), .half_cy(pair_h), .full_cy(pair_c)
  );

  addr_offset_add #(.W(W), .O_W(O_W)) u_ofs (
    .base(opnd_a), .ofs(offset), .sum(ofs_sum), .nib_cy(ofs_h), .byte_cy(ofs_c)
  );

  addr_step #(.W(W), .DOWN(1'b0)) u_up (.val(opnd_a), .nxt(up_val));
  addr_step #(.W(W), .DOWN(1'b1)) u_dn (.val(opnd_a), .nxt(dn_val));

  addr_cond_eval u_cc (.flags(flags_in), .sel(cond_sel), .taken(cc_ok));

  logic [W-1:0]      res_d;
  logic [FLAG_W-1:0] flg_d;
  logic              cc_d, known_d;

  always_comb begin
    res_d   = opnd_a;
    flg_d   = flags_in;
    cc_d    = 1'b0;
    known_d = 1'b1;
    case (op_sel)
      OP_PAIR_ADD: begin
        res_d     = pair_sum;
        flg_d[FN] = 1'b0;
        flg_d[FH] = pair_h;
        flg_d[FC] = pair_c;
      end
      OP_INC, OP_PTR_INC: res_d = up_val;
      OP_DEC, OP_PTR_DEC: res_d = dn_val;
      OP_OFS_SP, OP_OFS_HL: begin
        res_d = ofs_sum;
        flg_d = {1'b0, 1'b0, ofs_h, ofs_c};
      end
      OP_JR_COND: begin
        res_d = ofs_sum;
        cc_d  = cc_ok;
      end
      OP_JR: begin
        res_d = ofs_sum;
        cc_d  = 1'b1;
      end
      default: known_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      flags_out <= '0;
      cond_met  <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= op_valid && known_d;
      if (op_valid && known_d) begin
        res_out   <= res_d;
        flags_out <= flg_d;
        cond_met  <= cc_d;
      end
    end
  end

  // R1: Z passes through and N is cleared on a pair add
  p_pair_zkeep_r1: assert property (@(posedge clk) disable iff (rst)
    res_valid && $past(op_sel) == OP_PAIR_ADD |->
      flags_out[FZ] == $past(flags_in[FZ]) && !flags_out[FN]);

  // R2: Z and N are forced low by both signed-offset forms
  p_ofs_zn_low_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid && ($past(op_sel) == OP_OFS_SP || $past(op_sel) == OP_OFS_HL) |->
      flags_out[FZ:FN] == 2'b00);

  // R3: a step of a pair or of SP leaves every flag untouched
  p_step_flags_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid && ($past(op_sel) == OP_INC || $past(op_sel) == OP_DEC) |->
      flags_out == $past(flags_in));

  // R7: an unconditional branch is always taken
  p_jr_taken_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid && $past(op_sel) == OP_JR |-> cond_met);

  // R7: a non-branch operation never reports a taken condition
  p_nonbr_idle_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid && $past(op_sel) < OP_JR_COND |-> !cond_met);

  // R9: with no load on the last edge, the result holds
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !res_valid && !$past(rst) |-> $stable(res_out) && $stable(flags_out));
endmodule

// File: tb/tb_addr_alu.sv
`timescale 1ns/1ps
module tb_addr_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_sel = 4'd0;
  logic [15:0] opnd_a = 16'd0, opnd_b = 16'd0;
  logic [7:0]  offset = 8'd0;
  logic [3:0]  flags_in = 4'd0;
  logic [1:0]  cond_sel = 2'd0;
  logic [15:0] res_out;
  logic [3:0]  flags_out;
  logic        cond_met, res_valid;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  addr_alu dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .offset(offset), .flags_in(flags_in),
    .cond_sel(cond_sel), .res_out(res_out), .flags_out(flags_out),
    .cond_met(cond_met), .res_valid(res_valid)
  );

  // Expected behaviour, written from the requirements
  task automatic model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [7:0] ofs, input logic [3:0] fl, input logic [1:0] cc,
                       output logic [15:0] r, output logic [3:0] f, output logic cm);
    logic [16:0] s17;
    logic [12:0] s13;
    logic [8:0]  s9;
    logic [4:0]  s5;
    logic [15:0] sx;
    logic        ccv;
    sx = {{8{ofs[7]}}, ofs};
    case (cc)
      2'd0: ccv = !fl[3];
      2'd1: ccv = fl[3];
      2'd2: ccv = !fl[0];
      default: ccv = fl[0];
    endcase
    r = a; f = fl; cm = 1'b0;
    case (op)
      4'd0: begin
        s17 = {1'b0, a} + {1'b0, b};
        s13 = {1'b0, a[11:0]} + {1'b0, b[11:0]};
        r = s17[15:0];
        f = {fl[3], 1'b0, s13[12], s17[16]};
      end
      4'd1, 4'd5: r = a + 16'd1;
      4'd2, 4'd6: r = a - 16'd1;
      4'd3, 4'd4: begin
        s9 = {1'b0, a[7:0]} + {1'b0, ofs};
        s5 = {1'b0, a[3:0]} + {1'b0, ofs[3:0]};
        r = a + sx;
        f = {2'b00, s5[4], s9[8]};
      end
      4'd7: begin r = a + sx; cm = ccv; end
      default: begin r = a + sx; cm = 1'b1; end
    endcase
  endtask

  task automatic run_op(input string tag, input logic [3:0] op, input logic [15:0] a,
                        input logic [15:0] b, input logic [7:0] ofs, input logic [3:0] fl,
                        input logic [1:0] cc);
    logic [15:0] er;
    logic [3:0]  ef;
    logic        ecm;
    model(op, a, b, ofs, fl, cc, er, ef, ecm);
    @(negedge clk);
    op_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
    offset = ofs; flags_in = fl; cond_sel = cc;
    @(negedge clk);
    op_valid = 1'b0;
    n_vec++;
    if (res_out !== er || flags_out !== ef || cond_met !== ecm || res_valid !== 1'b1) begin
      n_bad++;
      $display("FAIL %s op=%0d: got res=%h fl=%b cc=%b v=%b, expected res=%h fl=%b cc=%b v=1",
               tag, op, res_out, flags_out, cond_met, res_valid, er, ef, ecm);
    end
  endtask

  // R9: idle or unknown op leaves the outputs where they were
  task automatic check_hold(input logic [3:0] op, input logic vld);
    logic [15:0] pr;
    logic [3:0]  pf;
    logic        pc;
    pr = res_out; pf = flags_out; pc = cond_met;
    @(negedge clk);
    op_valid = vld; op_sel = op; opnd_a = 16'h5A5A; flags_in = 4'b1111; offset = 8'h11;
    @(negedge clk);
    op_valid = 1'b0;
    n_vec++;
    if (res_valid !== 1'b0 || res_out !== pr || flags_out !== pf || cond_met !== pc) begin
      n_bad++;
      $display("FAIL R9 hold op=%0d: got v=%b res=%h fl=%b cc=%b, expected v=0 res=%h fl=%b cc=%b",
               op, res_valid, res_out, flags_out, cond_met, pr, pf, pc);
    end
  endtask

  task automatic t_reset();
    n_vec++;
    if (res_out !== 16'h0 || flags_out !== 4'h0 || cond_met !== 1'b0 || res_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset: got res=%h fl=%b cc=%b v=%b, expected all zero",
               res_out, flags_out, cond_met, res_valid);
    end
  endtask

  task automatic t_pair_add();
    run_op("R1 0x0FFF+1 half carry", 4'd0, 16'h0FFF, 16'h0001, 8'h00, 4'b1100, 2'd0);
    run_op("R1 R11 0xFFFF+1", 4'd0, 16'hFFFF, 16'h0001, 8'h00, 4'b0111, 2'd0);
    run_op("R1 0x8000+0x8000", 4'd0, 16'h8000, 16'h8000, 8'h00, 4'b1000, 2'd0);
    run_op("R1 no carry", 4'd0, 16'h1234, 16'h0101, 8'h00, 4'b0011, 2'd0);
  endtask

  task automatic t_offset();
    run_op("R2 SP zero result keeps Z low", 4'd3, 16'hFFF8, 16'h0, 8'h08, 4'b1100, 2'd0);
    run_op("R2 offset 0x7F", 4'd3, 16'h1000, 16'h0, 8'h7F, 4'b0000, 2'd0);
    run_op("R2 offset 0x80", 4'd4, 16'h1000, 16'h0, 8'h80, 4'b1111, 2'd0);
    run_op("R2 0x00FF+0x80", 4'd4, 16'h00FF, 16'h0, 8'h80, 4'b0000, 2'd0);
    run_op("R2 offset -1", 4'd3, 16'h0001, 16'h0, 8'hFF, 4'b0000, 2'd0);
  endtask

  task automatic t_step();
    run_op("R3 R11 inc 0xFFFF", 4'd1, 16'hFFFF, 16'h0, 8'h00, 4'b1010, 2'd0);
    run_op("R3 R11 dec 0x0000", 4'd2, 16'h0000, 16'h0, 8'h00, 4'b0101, 2'd0);
    run_op("R4 ptr post-inc", 4'd5, 16'hC0FF, 16'h0, 8'h00, 4'b1001, 2'd0);
    run_op("R4 ptr post-dec", 4'd6, 16'hC100, 16'h0, 8'h00, 4'b0110, 2'd0);
  endtask

  task automatic t_branch();
    run_op("R5 R6 back, Z clear taken", 4'd7, 16'h0150, 16'h0, 8'hFE, 4'b0000, 2'd0);
    run_op("R5 R6 Z clear not taken", 4'd7, 16'h0150, 16'h0, 8'h10, 4'b1000, 2'd0);
    run_op("R6 Z set taken", 4'd7, 16'h0200, 16'h0, 8'h7F, 4'b1000, 2'd1);
    run_op("R6 C clear not taken", 4'd7, 16'h0200, 16'h0, 8'h80, 4'b0001, 2'd2);
    run_op("R6 C set taken", 4'd7, 16'hFFF0, 16'h0, 8'h20, 4'b0001, 2'd3);
    run_op("R7 unconditional", 4'd8, 16'h4000, 16'h0, 8'h80, 4'b0000, 2'd1);
  endtask

  task automatic t_hold();
    check_hold(4'd0, 1'b0);
    check_hold(4'd9, 1'b1);
    check_hold(4'd15, 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pair_add();
        t_offset();
        t_step();
        t_branch();
        t_hold();
        run_op("R8 back-to-back after idle", 4'd0, 16'h7FFF, 16'h0001, 8'h00, 4'b0000, 2'd0);
      end
      begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule